// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column addresses of one SDRAM burst, one per clock. A start pulse loads an 8-bit start column, a burst length code, an ordering selection and a flag that says whether the access is a write. The block then steps through the burst. Each column comes out with a valid flag. The first column also carries a first flag, and the closing column of a fixed-length burst carries a last flag.

Two orderings are available. Sequential ordering counts upward and wraps inside the aligned block. Interleaved ordering XORs the beat index into the low bits. The full-page length runs through all 256 columns modulo 256 and keeps going until a stop input ends it. A single-write mode input forces every write to one column while reads keep the programmed length. This matches a memory that bursts on reads but writes single words. Command decoding and the data path belong to neighbouring logic.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `valid`, `first` and `last` are low.
- R2: A `start` pulse while `valid` is low is accepted. On the next cycle `valid` is high and `col` equals `start_col`. `first` is high on that column only.
- R3: `len_code` selects the burst length: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4, 5 and 6 give a single column.
- R4: When `ilv_mode` is 0 (sequential) on a fixed length L, beat k has low log2(L) bits equal to (start low bits + k) mod L. The upper bits equal those of the start column.
- R5: When `ilv_mode` is 1 (interleaved) on a fixed length L, beat k has low log2(L) bits equal to the start low bits XOR k. The upper bits are held.
- R6: A full-page burst outputs (start_col + k) mod 256 on beat k, whatever `ilv_mode` is. It never raises `last` and runs past 256 beats until stopped.
- R7: If `stop` is high on a cycle where a full-page column is valid, that column is the final one and `valid` is low on the next cycle. `stop` has no effect on fixed-length bursts.
- R8: `last` is high on the final column of a fixed-length burst, and `valid` is low on the next cycle.
- R9: When `single_wr` is 1 and `is_write` is 1 at start, the burst is one column whatever its length code. Reads still use the programmed length. When `single_wr` is 0, writes use the programmed length.
- R10: A `start` pulse while `valid` is high is ignored. The running burst continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a burst when idle |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length selection |
| ilv_mode | input | 1 | 0 sequential, 1 interleaved |
| is_write | input | 1 | Access is a write |
| single_wr | input | 1 | Force writes to one column |
| stop | input | 1 | Ends a full-page burst after the current column |
| col | output | 8 | Current column address |
| valid | output | 1 | `col` holds a burst column |
| first | output | 1 | First column of the burst |
| last | output | 1 | Final column of a fixed-length burst |

## Verification
The assertions take it that `start` only counts when the block is idle, so a new burst never begins in the cycle after `last`. They also take it that `stop` matters only in full-page bursts. The stimulus drives all inputs on the falling edge and samples outputs on the falling edge. It releases `start` after one cycle except in the deliberate start-while-busy case. It raises `stop` for exactly one column, then drops it before the idle check.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv_mode,
  input  logic             is_write,
  input  logic             single_wr,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             first,
  output logic             last
);
  logic             busy, first_r, full_r, ilv_r;
  logic [COL_W-1:0] base, k, mask_r, len_mask;
  logic             fp, one_wr, accept;

  assign fp     = (len_code == 3'd7);
  assign one_wr = is_write && single_wr;
  assign accept = start && !busy;

  always_comb begin
    case (len_code)
      3'd1:    len_mask = COL_W'(1);
      3'd2:    len_mask = COL_W'(3);
      3'd3:    len_mask = COL_W'(7);
      3'd7:    len_mask = '1;
      default: len_mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      first_r <= 1'b0;
      full_r  <= 1'b0;
      ilv_r   <= 1'b0;
      base    <= '0;
      k       <= '0;
      mask_r  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      first_r <= 1'b1;
      full_r  <= fp && !one_wr;
      ilv_r   <= ilv_mode && !fp;
      base    <= start_col;
      k       <= '0;
      mask_r  <= one_wr ? '0 : len_mask;
    end else if (busy) begin
      first_r <= 1'b0;
      if (last || (full_r && stop)) busy <= 1'b0;
      else k <= k + 1'b1;
    end
  end

  assign col   = (base & ~mask_r) | ((ilv_r ? (base ^ k) : (base + k)) & mask_r);
  assign valid = busy;
  assign first = busy && first_r;
  assign last  = busy && !full_r && (k == mask_r);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !valid && !first && !last);
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> valid && first && col == $past(start_col));
  a_r2_first_once: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid)) |-> !first);
  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !valid);
  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && full_r && stop) |=> !valid);
  a_r4_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !first) |-> ((col & ~mask_r) == ($past(col) & ~mask_r)));
  a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !first && !ilv_r) |-> ((col & mask_r) == (($past(col) + 1'b1) & mask_r)));
  a_r10_ignore_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && valid && !last) |=> valid && !first);
endmodule

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, ilv_mode = 0, is_write = 0, single_wr = 0, stop = 0;
  logic [7:0] start_col = 0;
  logic [2:0] len_code = 0;
  logic [7:0] col;
  logic valid, first, last;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  burst_col_seq u0 (.clk, .rst_n, .start, .start_col, .len_code, .ilv_mode,
    .is_write, .single_wr, .stop, .col, .valid, .first, .last);

  // {stop_at[7:0], len_code[2:0], ilv, wr, single_wr, start_col[7:0]}, stop_at FF = none
  localparam int NV = 14;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {8'hFF, 3'd0, 1'b0, 1'b0, 1'b0, 8'h35},
    {8'hFF, 3'd1, 1'b0, 1'b0, 1'b0, 8'h35},
    {8'hFF, 3'd2, 1'b0, 1'b0, 1'b0, 8'h36},
    {8'hFF, 3'd3, 1'b0, 1'b0, 1'b0, 8'h5D},
    {8'hFF, 3'd2, 1'b1, 1'b0, 1'b0, 8'h35},
    {8'hFF, 3'd3, 1'b1, 1'b0, 1'b0, 8'h5D},
    {8'hFF, 3'd3, 1'b0, 1'b1, 1'b1, 8'h44},
    {8'hFF, 3'd3, 1'b0, 1'b0, 1'b1, 8'h44},
    {8'hFF, 3'd3, 1'b0, 1'b1, 1'b0, 8'h44},
    {8'hFF, 3'd5, 1'b0, 1'b0, 1'b0, 8'h77},
    {8'd9,  3'd7, 1'b0, 1'b0, 1'b0, 8'hFA},
    {8'd4,  3'd7, 1'b1, 1'b0, 1'b0, 8'h13},
    {8'd5,  3'd7, 1'b0, 1'b1, 1'b1, 8'h20},
    {8'd1,  3'd2, 1'b0, 1'b0, 1'b0, 8'hC2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [2:0] c, input bit wr, input bit sw);
    if (wr && sw) return 1;
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [7:0] s, input int n, input bit il, input int k);
    int off, blk;
    if (n == 256) return 8'(s + k);
    off = s % n;
    blk = s - off;
    if (il) return 8'(blk + (off ^ k));
    return 8'(blk + ((off + k) % n));
  endfunction

  task automatic run(input logic [2:0] c, input bit il, input bit wr, input bit sw,
                     input logic [7:0] s, input int stop_at, input int inj_at, input string tag);
    int n, cnt;
    n = blen(c, wr, sw);
    cnt = (n == 256) ? stop_at + 1 : n;
    @(negedge clk);
    start = 1; len_code = c; ilv_mode = il; is_write = wr; single_wr = sw; start_col = s;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < cnt; i++) begin
      chk(valid === 1'b1, {tag, " R2 valid"}, valid, 1);
      chk(col === model(s, n, il && n != 256, i), {tag, " R4 R5 R6 col"}, col, model(s, n, il && n != 256, i));
      chk(first === (i == 0), {tag, " R2 first"}, first, i == 0);
      chk(last === (n != 256 && i == n - 1), {tag, " R8 last"}, last, n != 256 && i == n - 1);
      stop = (i == stop_at);
      if (i == inj_at) begin start = 1; start_col = ~s; len_code = 3'd0; end
      else start = 0;
      @(negedge clk);
    end
    stop = 0; start = 0;
    chk(valid === 1'b0, {tag, " R7 R8 R9 end"}, valid, 0);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid === 1'b0 && first === 1'b0 && last === 1'b0, "R1 reset", {valid, first, last}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(valid === 1'b0 && first === 1'b0 && last === 1'b0, "R1 after reset", {valid, first, last}, 0);
    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VEC[v];
      run(e[13:11], e[10], e[9], e[8], e[7:0], (e[21:14] == 8'hFF) ? -1 : int'(e[21:14]), -1,
          $sformatf("vec%0d R3 R9", v));
    end
    run(3'd3, 1'b0, 1'b0, 1'b0, 8'h9B, -1, 2, "R10 start while busy");
    run(3'd2, 1'b1, 1'b0, 1'b0, 8'h0E, -1, 0, "R10 start on first beat");
    run(3'd7, 1'b0, 1'b0, 1'b0, 8'h80, 299, -1, "R6 long full page");
    run(3'd7, 1'b1, 1'b1, 1'b0, 8'hFF, 0, -1, "R7 stop on first beat");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule